// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block drives one DRAM bank through its three access steps: opening a row, reading or writing a column, and closing the row by precharging the bit lines. A requester hands it one access at a time with a flat address. The block splits that address into a row part and a column part and puts them on a single shared command address bus, the row first and then the column. After each step it waits a set number of clock cycles before it issues the next step.

The block remembers which row is open. A request to that row goes straight to the column step, so a run of accesses to one row becomes a burst of column commands. A request to a different row first precharges the open row and then activates the new one. The row stays open when an access finishes. Read data is returned with a one-cycle done pulse.

The request side is a valid/ready interface. Ready is high only while the block is idle. A request is taken on a clock edge where both valid and ready are high. The requester must then hold valid, write flag, address and write data steady until that edge. Ready stays low from the accepting edge through the cycle that carries done, so only one access is in flight at a time.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, req_ready is high, no command strobe or rsp_done is asserted, and no row is open, so the first request starts with an activate and has no precharge.
- R2: The row is the upper ROW_W bits of req_addr and the column is the lower COL_W bits. mem_addr carries the row, zero-extended, in the activate cycle and the column, zero-extended, in the column cycle.
- R3: A request that arrives with no row open issues an activate in the first cycle after acceptance and a column command T_ACT cycles later. rsp_done follows T_CAS cycles after that, which is T_ACT+T_CAS+1 cycles after the accepting edge.
- R4: A request to the open row issues only a column command, in the first cycle after acceptance. rsp_done follows T_CAS+1 cycles after the accepting edge.
- R5: A request to a row other than the open one issues a precharge, then an activate T_PRE cycles later, then a column command T_ACT cycles after that, always in this order. rsp_done follows T_PRE+T_ACT+T_CAS+1 cycles after the accepting edge.
- R6: Each command strobe (mem_pre, mem_act, mem_cas) is high for exactly one cycle, and at most one strobe is high in any cycle.
- R7: req_ready is high only while the block is idle, and it stays low from the accepting edge through the rsp_done cycle. A request is taken only when req_valid and req_ready are both high at a clock edge.
- R8: rsp_done is a one-cycle pulse, and req_ready is high in the following cycle. On a read, rsp_rdata holds the mem_rdata value sampled in the last cycle of the column wait, and it keeps that value until the next read completes.
- R9: mem_we is high only together with mem_cas of a write request, and mem_wdata then carries that request's req_wdata.
- R10: The row stays open after an access completes. Only a request to a different row precharges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request is present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| mem_pre | output | 1 | Precharge strobe |
| mem_act | output | 1 | Row activate strobe |
| mem_cas | output | 1 | Column access strobe |
| mem_we | output | 1 | Column access is a write |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| mem_wdata | output | DATA_W | Column write data |
| mem_rdata | input | DATA_W | Column read data from the bank |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data of the last completed read |

## Verification
The hardest case to reach is a precharge that must write data back. A row that was changed only in the sense latches by a burst of hit writes must be written back by a precharge before a later miss can read it. The bench writes every location in row-major order, which makes long hit bursts and leaves the last row dirty in the latches. It then reads every location in column-major order, so every read is a row miss that depends on an earlier write-back. The bench checks the exact cycle of every strobe, the value on the shared address bus and the latency of every access against its expected class: closed, hit or miss.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACT  = 3'd2,
    ST_CAS  = 3'd3,
    ST_WAIT = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic write;
    logic pre_needed;
    logic act_needed;
  } req_class_t;
endpackage

// File: rtl/dbs_addr_split.sv
module dbs_addr_split #(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  parameter int AB_W  = 4
) (
  input  logic [ROW_W+COL_W-1:0] flat_addr,
  output logic [ROW_W-1:0]       row_part,
  output logic [COL_W-1:0]       col_part,
  output logic [AB_W-1:0]        row_bus,
  output logic [AB_W-1:0]        col_bus
);
  assign row_part = flat_addr[ROW_W+COL_W-1:COL_W];
  assign col_part = flat_addr[COL_W-1:0];
  assign row_bus  = AB_W'(row_part);
  assign col_bus  = AB_W'(col_part);
endmodule

// File: rtl/dbs_open_row.sv
module dbs_open_row #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] query_row,
  output logic             open_valid,
  output logic             row_hit
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_row_q <= '0;
    end else if (open_set) begin
      open_valid <= 1'b1;
      open_row_q <= set_row;
    end else if (open_clr) begin
      open_valid <= 1'b0;
    end
  end

  assign row_hit = open_valid && (open_row_q == query_row);

  // R10: an open row is only closed by a precharge
  a_r10_row_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (open_valid && !open_clr) |=> open_valid);
endmodule

// File: rtl/dbs_phase_timer.sv
module dbs_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R6: once the timer reaches zero it stays idle until the next load
  a_r6_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_PRE  = 4,
  parameter int T_ACT  = 4,
  parameter int T_CAS  = 4,
  localparam int AB_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int A_W   = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [A_W-1:0]    req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_pre,
  output logic              mem_act,
  output logic              mem_cas,
  output logic              mem_we,
  output logic [AB_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int T_MAX1 = (T_PRE > T_ACT ? (T_PRE > T_CAS ? T_PRE : T_CAS)
                                         : (T_ACT > T_CAS ? T_ACT : T_CAS));
  localparam int CNT_W  = $clog2(T_MAX1 + 1);

  initial begin
    if (T_PRE < 2 || T_ACT < 2 || T_CAS < 2)
      $error("phase delays must be at least 2 cycles");
  end

  seq_state_e state_q, after_wait_q;
  logic [A_W-1:0]    addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic [DATA_W-1:0] rdata_q;

  logic [ROW_W-1:0] in_row, held_row;
  logic [COL_W-1:0] in_col, held_col;
  logic [AB_W-1:0]  in_row_bus, in_col_bus, row_bus, col_bus;
  logic             open_valid, row_hit;
  logic             tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_val;
  logic             accept;

  dbs_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .AB_W(AB_W)) u_split_in (
    .flat_addr(req_addr), .row_part(in_row), .col_part(in_col),
    .row_bus(in_row_bus), .col_bus(in_col_bus)
  );

  dbs_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .AB_W(AB_W)) u_split_held (
    .flat_addr(addr_q), .row_part(held_row), .col_part(held_col),
    .row_bus(row_bus), .col_bus(col_bus)
  );

  dbs_open_row #(.ROW_W(ROW_W)) u_open (
    .clk(clk), .rst_n(rst_n),
    .open_set(mem_act), .open_clr(mem_pre),
    .set_row(held_row), .query_row(in_row),
    .open_valid(open_valid), .row_hit(row_hit)
  );

  dbs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expire(tmr_expire)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_pre   = (state_q == ST_PRE);
  assign mem_act   = (state_q == ST_ACT);
  assign mem_cas   = (state_q == ST_CAS);
  assign mem_we    = mem_cas && write_q;
  assign mem_wdata = wdata_q;
  assign rsp_done  = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign tmr_load  = mem_pre || mem_act || mem_cas;

  always_comb begin
    mem_addr = '0;
    if (mem_act) mem_addr = row_bus;
    if (mem_cas) mem_addr = col_bus;
  end

  always_comb begin
    tmr_val = CNT_W'(T_CAS - 1);
    if (mem_pre) tmr_val = CNT_W'(T_PRE - 1);
    if (mem_act) tmr_val = CNT_W'(T_ACT - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      after_wait_q <= ST_IDLE;
      addr_q       <= '0;
      wdata_q      <= '0;
      write_q      <= 1'b0;
      rdata_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          if (row_hit)         state_q <= ST_CAS;
          else if (open_valid) state_q <= ST_PRE;
          else                 state_q <= ST_ACT;
        end
        ST_PRE: begin state_q <= ST_WAIT; after_wait_q <= ST_ACT;  end
        ST_ACT: begin state_q <= ST_WAIT; after_wait_q <= ST_CAS;  end
        ST_CAS: begin state_q <= ST_WAIT; after_wait_q <= ST_DONE; end
        ST_WAIT: if (tmr_expire) begin
          state_q <= after_wait_q;
          if (after_wait_q == ST_DONE && !write_q) rdata_q <= mem_rdata;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: at most one command strobe per cycle
  a_r6_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_pre, mem_act, mem_cas}));
  // R6: a strobe never lasts two cycles
  a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pre || mem_act || mem_cas) |=> !(mem_pre || mem_act || mem_cas));
  // R7: busy right after acceptance
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R5: activation only on a closed bank
  a_r5_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_act |-> !open_valid);
  // R4: column command only with a row open
  a_r4_cas_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cas |-> open_valid);
  // R8: done is a single pulse followed by ready
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  // R9: write enable only with a column command
  a_r9_we_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_cas);
endmodule

// File: tb/dram_bank_seq_tb.sv
`timescale 1ns/1ps
module dram_bank_seq_tb;
  localparam int ROW_W = 4, COL_W = 3, DATA_W = 16;
  localparam int TP = 3, TA = 4, TC = 2;
  localparam int AB_W = 4;
  localparam int NROW = 1 << ROW_W, NCOL = 1 << COL_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, mem_pre, mem_act, mem_cas, mem_we, rsp_done;
  logic [AB_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, rsp_rdata;

  int n_chk = 0, n_bad = 0;
  bit b_open = 0;
  int b_row = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                  .T_PRE(TP), .T_ACT(TA), .T_CAS(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_pre(mem_pre), .mem_act(mem_act), .mem_cas(mem_cas), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  // behavioural bank: array plus one row of sense latches
  logic [DATA_W-1:0] arr [NROW][NCOL];
  logic [DATA_W-1:0] latch [NCOL];
  int lat_row = 0;
  logic [DATA_W-1:0] rd_q = '0;
  assign mem_rdata = rd_q;

  initial begin
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) arr[r][c] = '0;
    for (int c = 0; c < NCOL; c++) latch[c] = '0;
  end

  always @(posedge clk) begin
    if (mem_act) begin
      for (int c = 0; c < NCOL; c++) latch[c] <= arr[mem_addr][c];
      lat_row <= int'(mem_addr);
    end
    if (mem_pre)
      for (int c = 0; c < NCOL; c++) arr[lat_row][c] <= latch[c];
    if (mem_cas && mem_we)  latch[mem_addr[COL_W-1:0]] <= mem_wdata;
    if (mem_cas && !mem_we) rd_q <= latch[mem_addr[COL_W-1:0]];
  end

  function automatic logic [DATA_W-1:0] wval(int r, int c);
    return DATA_W'(r * 131 + c * 17 + 165);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one access; expected timing follows R3/R4/R5 from the bench's own row tracking
  task automatic do_req(bit wr, int r, int c, logic [DATA_W-1:0] wd,
                        logic [DATA_W-1:0] exp_rd);
    int t_pre, t_act, t_cas, lat, cyc;
    bit seq_ok, rdy_ok, addr_ok, we_ok;
    string cls;
    t_pre = -1; t_act = -1;
    if (!b_open)          begin cls = "R3"; t_act = 1; t_cas = 1 + TA; end
    else if (b_row == r)  begin cls = "R4"; t_cas = 1; end
    else begin cls = "R5"; t_pre = 1; t_act = 1 + TP; t_cas = 1 + TP + TA; end
    lat = t_cas + TC;
    req_valid = 1; req_write = wr;
    req_addr = {ROW_W'(r), COL_W'(c)};
    req_wdata = wr ? wd : 16'hDEAD;
    while (!req_ready) @(negedge clk);
    cyc = 0; seq_ok = 1; rdy_ok = 1; addr_ok = 1; we_ok = 1;
    do begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (req_ready) rdy_ok = 0;
      if ({mem_pre, mem_act, mem_cas} !=
          {cyc == t_pre, cyc == t_act, cyc == t_cas}) seq_ok = 0;
      if (mem_act && mem_addr != AB_W'(r)) addr_ok = 0;
      if (mem_cas && mem_addr != AB_W'(c)) addr_ok = 0;
      if (mem_we != (mem_cas && wr)) we_ok = 0;
      if (mem_cas && wr && mem_wdata != wd) we_ok = 0;
    end while (!rsp_done && cyc < 200);
    check(cyc == lat, cls, "latency", cyc, lat);
    check(seq_ok, "R6", "strobe order/spacing", int'(seq_ok), 1);
    check(rdy_ok, "R7", "ready low while busy", int'(rdy_ok), 1);
    check(addr_ok, "R2", "shared address", int'(addr_ok), 1);
    check(we_ok, "R9", "write strobe/data", int'(we_ok), 1);
    if (!wr) check(rsp_rdata == exp_rd, "R8", "read data",
                   int'(rsp_rdata), int'(exp_rd));
    b_open = 1; b_row = r;  // R10: row kept open
    @(negedge clk);
    check(!rsp_done && req_ready, "R8", "done pulse then ready",
          int'({rsp_done, req_ready}), 1);
    if (!wr) check(rsp_rdata == exp_rd, "R8", "read data held",
                   int'(rsp_rdata), int'(exp_rd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !mem_pre && !mem_act && !mem_cas && !rsp_done,
          "R1", "reset outputs", int'({req_ready, mem_pre, mem_act, mem_cas, rsp_done}), 16);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_done, "R1", "idle after reset", int'(req_ready), 1);
    // row-major writes: bursts of hits, one miss per new row (R1 first is closed)
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) do_req(1, r, c, wval(r, c), '0);
    // column-major reads: every access a row miss, depends on write-back
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) do_req(0, r, c, '0, wval(r, c));
    // hit read-after-write inside the open latches (R4, R10)
    do_req(1, 9, 2, 16'hBEEF, '0);
    do_req(0, 9, 2, '0, 16'hBEEF);
    do_req(0, 9, 5, '0, wval(9, 5));
    do_req(0, 3, 2, '0, wval(3, 2));
    do_req(0, 9, 2, '0, 16'hBEEF);
    // a write leaves rsp_rdata unchanged (R8)
    do_req(1, 9, 7, 16'h1111, '0);
    check(rsp_rdata == 16'hBEEF, "R8", "rdata kept over write",
          int'(rsp_rdata), 16'hBEEF);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule